// File: doc/BRIEF.md
# Syllable-Aligned Instruction Fetcher

This block sits between main store and the instruction decoder. Main store hands it 48-bit words. Each word carries six 8-bit syllables, and an instruction takes one, two or three of them. Instructions are packed with no gaps, so one may start in one word and finish in the next. The fetcher keeps up to two words of syllables in a realigning buffer and asks for the next word before the current one is used up. It hands the decoder one whole instruction at a time over a valid/ready port, together with its length and the split fields of each syllable.

A jump input gives a word address and a syllable index. A jump empties the buffer and cancels any memory answer still on its way. Fetching then starts again at the target word, and the syllables in front of the target index are thrown away. A jump to syllable 0 of the next word skips padding up to a word boundary.

Top module: `syl_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, `ins_valid` is 0 and `mem_req_valid` is 1 with `mem_req_addr` equal to the reset address (0 by default).
- R2: The instruction length comes from bits 7:6 of its first syllable: 11 means 3 syllables, 10 means 2, and 00 or 01 mean 1. `ins_len` carries the value 1, 2 or 3.
- R3: Syllables are taken from a word starting at bits 47:40 and ending at bits 7:0. `ins_syl` holds the first syllable in bits 23:16, the second in 15:8 and the third in 7:0, and any slot past the length is zero.
- R4: An instruction whose syllables lie in two consecutive words is delivered whole, in order, as one output.
- R5: A request is raised only when the buffer holds 6 or fewer syllables, no answer is outstanding and no jump is present. At most one request is outstanding, and consecutive requests use consecutive word addresses.
- R6: `ins_valid` is 1 exactly when the buffer holds at least as many syllables as the head instruction needs and no jump is present.
- R7: With `ins_ready` held high and enough syllables buffered, one instruction leaves on every clock.
- R8: While `ins_valid` is 1 and `ins_ready` is 0, `ins_syl` and `ins_len` do not change until the transfer or a jump.
- R9: A jump drops `ins_valid` in its own cycle and empties the buffer. The first word fetched afterwards is the target word, and its syllables before the target index are discarded.
- R10: A memory answer that was requested before a jump is ignored, whether it arrives in the jump cycle or later.
- R11: For each syllable slot j (0 = first), `ins_kind`, `ins_oct_a` and `ins_oct_b` carry its bits 7:6, 5:3 and 2:0, with slot 0 in the top field.
- R12: A jump to syllable 0 of the word after the current one restarts cleanly at that word boundary.
- R13: A jump with syllable index 6 or 7 discards the whole first word fetched, and delivery starts with the word after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req_valid | output | 1 | Word fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word address requested |
| mem_resp_valid | input | 1 | Requested word is present |
| mem_resp_word | input | 48 | Returned word |
| jmp_valid | input | 1 | Jump request |
| jmp_word | input | ADDR_W | Target word address |
| jmp_syl | input | 3 | Target syllable index |
| ins_valid | output | 1 | Instruction available |
| ins_ready | input | 1 | Decoder takes the instruction |
| ins_len | output | 2 | Length in syllables |
| ins_syl | output | 24 | Instruction syllables, zero-padded |
| ins_kind | output | 6 | Bits 7:6 of each syllable |
| ins_oct_a | output | 9 | Bits 5:3 of each syllable |
| ins_oct_b | output | 9 | Bits 2:0 of each syllable |

## Verification
The bench targets instructions that cross a word boundary. A fetcher that failed to join the two words would emit an instruction that is too short or has its syllables shuffled, and that shows at once in `ins_syl`. The bench also times jumps to fall while an answer is still due, both in the jump cycle and later. A design that accepted such a stale word would put syllables from the old path at the head of the queue. Jumps with nonzero, boundary and out-of-range syllable indices check the skip count: a wrong count shifts every instruction after it. Random back-pressure and late grants check that the output is held steady, that only one request is outstanding, and that the buffer never takes in a word it has no room for.

// File: rtl/sylfetch_pkg.sv
package sylfetch_pkg;
  localparam int SYL_W   = 8;
  localparam int MAX_LEN = 3;

  typedef logic [SYL_W-1:0] syl_t;

  // length in syllables from the leading 2-bit field
  function automatic logic [1:0] syl_len(input syl_t s);
    case (s[7:6])
      2'b11:   return 2'd3;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/syl_queue.sv
module syl_queue
  import sylfetch_pkg::*;
#(
  parameter int SYLS = 6,
  parameter int SKW  = 3,
  parameter int CW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [1:0]                 pop_amt,
  input  logic                       push,
  input  logic [SYLS*SYL_W-1:0]      push_word,
  input  logic [SKW-1:0]             push_skip,
  output logic [MAX_LEN*SYL_W-1:0]   head,
  output logic [CW-1:0]              fill
);
  localparam int DEPTH = 2 * SYLS;
  localparam int IW    = $clog2(DEPTH);
  localparam int SW    = $clog2(SYLS);

  syl_t sbuf [DEPTH];
  syl_t nxt  [DEPTH];
  syl_t wsyl [SYLS];
  logic [CW-1:0] keep, app;

  for (genvar w = 0; w < SYLS; w++) begin : g_split
    assign wsyl[w] = push_word[(SYLS-w)*SYL_W-1 -: SYL_W];
  end

  assign keep = fill - CW'(pop_amt);
  assign app  = (!push || push_skip >= SKW'(SYLS)) ? '0 : CW'(SYLS) - CW'(push_skip);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [CW:0] src, off;
    logic [CW:0] widx;
    always_comb begin
      src    = (CW+1)'(g) + (CW+1)'(pop_amt);
      off    = (CW+1)'(g) - (CW+1)'(keep);
      widx   = off + (CW+1)'(push_skip);
      nxt[g] = '0;
      if (src < (CW+1)'(fill))
        nxt[g] = sbuf[src[IW-1:0]];
      else if ((CW+1)'(g) >= (CW+1)'(keep) && off < (CW+1)'(app))
        nxt[g] = wsyl[widx[SW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) sbuf[i] <= '0;
    end else if (flush) begin
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) sbuf[i] <= '0;
    end else begin
      fill <= keep + app;
      for (int i = 0; i < DEPTH; i++) sbuf[i] <= nxt[i];
    end
  end

  for (genvar j = 0; j < MAX_LEN; j++) begin : g_head
    assign head[(MAX_LEN-j)*SYL_W-1 -: SYL_W] = sbuf[j];
  end

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R6
  pop_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_amt != 2'd0) |-> (CW'(pop_amt) <= fill));
endmodule

// File: rtl/fetch_ctl.sv
module fetch_ctl #(
  parameter int ADDR_W     = 15,
  parameter int SYLS       = 6,
  parameter int SKW        = 3,
  parameter int CW         = 4,
  parameter int RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_valid,
  input  logic [ADDR_W-1:0] jmp_word,
  input  logic [SKW-1:0]    jmp_syl,
  input  logic [CW-1:0]     fill,
  input  logic              req_ready,
  input  logic              resp_valid,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              push,
  output logic [SKW-1:0]    skip
);
  logic outst, drop;
  logic req_fire;

  assign req_valid = !jmp_valid && !outst && (fill <= CW'(SYLS));
  assign req_fire  = req_valid && req_ready;
  assign push      = resp_valid && !drop && !jmp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= ADDR_W'(RESET_ADDR);
      skip     <= '0;
      outst    <= 1'b0;
      drop     <= 1'b0;
    end else begin
      if (jmp_valid) begin
        req_addr <= jmp_word;
        skip     <= jmp_syl;
        drop     <= outst && !resp_valid;
      end else begin
        if (req_fire) req_addr <= req_addr + 1'b1;
        if (push)     skip <= '0;
        if (resp_valid) drop <= 1'b0;
      end
      if (req_fire)        outst <= 1'b1;
      else if (resp_valid) outst <= 1'b0;
    end
  end

  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (req_addr == $past(req_addr) + 1'b1));

  // R10
  resp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> outst);
endmodule

// File: rtl/syl_fetch.sv
module syl_fetch
  import sylfetch_pkg::*;
#(
  parameter int SYLS       = 6,
  parameter int ADDR_W     = 15,
  parameter int RESET_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-1:0]           mem_req_addr,
  input  logic                        mem_resp_valid,
  input  logic [SYLS*SYL_W-1:0]       mem_resp_word,
  input  logic                        jmp_valid,
  input  logic [ADDR_W-1:0]           jmp_word,
  input  logic [$clog2(SYLS)-1:0]     jmp_syl,
  output logic                        ins_valid,
  input  logic                        ins_ready,
  output logic [1:0]                  ins_len,
  output logic [MAX_LEN*SYL_W-1:0]    ins_syl,
  output logic [MAX_LEN*2-1:0]        ins_kind,
  output logic [MAX_LEN*3-1:0]        ins_oct_a,
  output logic [MAX_LEN*3-1:0]        ins_oct_b
);
  localparam int DEPTH = 2 * SYLS;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int SKW   = $clog2(SYLS);

  logic [MAX_LEN*SYL_W-1:0] head;
  logic [CW-1:0]            fill;
  logic                     push;
  logic [SKW-1:0]           skip;
  logic [1:0]               pop_amt;
  logic                     ins_fire;
  syl_t                     lead;

  assign lead      = head[MAX_LEN*SYL_W-1 -: SYL_W];
  assign ins_len   = syl_len(lead);
  assign ins_valid = !jmp_valid && (fill != '0) && (fill >= CW'(ins_len));
  assign ins_fire  = ins_valid && ins_ready;
  assign pop_amt   = ins_fire ? ins_len : 2'd0;

  fetch_ctl #(
    .ADDR_W(ADDR_W), .SYLS(SYLS), .SKW(SKW), .CW(CW), .RESET_ADDR(RESET_ADDR)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .jmp_valid  (jmp_valid),
    .jmp_word   (jmp_word),
    .jmp_syl    (jmp_syl),
    .fill       (fill),
    .req_ready  (mem_req_ready),
    .resp_valid (mem_resp_valid),
    .req_valid  (mem_req_valid),
    .req_addr   (mem_req_addr),
    .push       (push),
    .skip       (skip)
  );

  syl_queue #(.SYLS(SYLS), .SKW(SKW), .CW(CW)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (jmp_valid),
    .pop_amt   (pop_amt),
    .push      (push),
    .push_word (mem_resp_word),
    .push_skip (skip),
    .head      (head),
    .fill      (fill)
  );

  for (genvar j = 0; j < MAX_LEN; j++) begin : g_pack
    syl_t s;
    assign s = (2'(j) < ins_len) ? head[(MAX_LEN-j)*SYL_W-1 -: SYL_W] : '0;
    assign ins_syl  [(MAX_LEN-j)*SYL_W-1 -: SYL_W] = s;
    assign ins_kind [(MAX_LEN-j)*2-1 -: 2]         = s[7:6];
    assign ins_oct_a[(MAX_LEN-j)*3-1 -: 3]         = s[5:3];
    assign ins_oct_b[(MAX_LEN-j)*3-1 -: 3]         = s[2:0];
  end

  // R8
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !jmp_valid) |=>
      (jmp_valid || (ins_valid && $stable(ins_syl) && $stable(ins_len))));

  // R9
  jump_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> !ins_valid);

  // R3
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_len != 2'd3) |-> (ins_syl[SYL_W-1:0] == '0));

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (ins_len != 2'd0));
endmodule

// File: tb/syl_fetch_tb.sv
module syl_fetch_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic mem_req_valid, mem_req_ready;
  logic [14:0] mem_req_addr;
  logic mem_resp_valid;
  logic [47:0] mem_resp_word;
  logic jmp_valid;
  logic [14:0] jmp_word;
  logic [2:0] jmp_syl;
  logic ins_valid, ins_ready;
  logic [1:0] ins_len;
  logic [23:0] ins_syl;
  logic [5:0] ins_kind;
  logic [8:0] ins_oct_a, ins_oct_b;

  always #5 clk = ~clk;

  syl_fetch u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_word(mem_resp_word),
    .jmp_valid(jmp_valid), .jmp_word(jmp_word), .jmp_syl(jmp_syl),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_len(ins_len), .ins_syl(ins_syl),
    .ins_kind(ins_kind), .ins_oct_a(ins_oct_a), .ins_oct_b(ins_oct_b)
  );

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [7:0] q[$];
  int m_addr = 0, m_skip = 0;
  bit m_out = 0, m_drop = 0;
  // memory model
  bit mbusy = 0;
  int mlat = 0, maddr = 0, lmax = 0;
  // previous-cycle hold tracking
  bit prev_hold = 0;
  logic [23:0] prev_syl;
  string phase = "R1";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, phase, act, exp);
    end
  endtask

  function automatic logic [47:0] memword(input int a);
    logic [47:0] w;
    for (int k = 0; k < 6; k++) w[47-8*k -: 8] = 8'(a * 53 + k * 101 + (a / 5) * 29 + 7);
    return w;
  endfunction

  function automatic int need(input logic [7:0] b);
    int t = b >> 6;
    if (t == 3) return 3;
    if (t == 2) return 2;
    return 1;
  endfunction

  task automatic cycle(input int mode);
    bit rdy, gnt, jv, rv;
    int js, jw, n, ev_len;
    bit ev, er, fo, fr;
    logic [23:0] es;
    @(negedge clk);
    rdy = 1; gnt = 1; jv = 0; js = 0; jw = 0;
    case (mode)
      0: lmax = 0;
      1: begin rdy = ($urandom % 2) == 0; gnt = ($urandom % 4) != 0; lmax = 3; end
      2: begin rdy = ($urandom % 4) != 0; lmax = 2;
               jv = ($urandom % 20) == 0; js = $urandom % 6; jw = $urandom % 64; end
      3: begin rdy = ($urandom % 3) != 0; lmax = 4;
               jv = m_out && (($urandom % 4) == 0); js = $urandom % 6; jw = $urandom % 64; end
      4: begin lmax = 1; jv = ($urandom % 16) == 0; js = 0; jw = (m_addr + 1) & 16'h7fff; end
      default: begin rdy = ($urandom % 4) != 0; lmax = 2;
               jv = ($urandom % 12) == 0; js = $urandom % 8; jw = $urandom % 64; end
    endcase
    rv = mbusy && mlat == 0;
    ins_ready = rdy; mem_req_ready = gnt;
    jmp_valid = jv; jmp_syl = 3'(js); jmp_word = 15'(jw);
    mem_resp_valid = rv; mem_resp_word = rv ? memword(maddr) : 48'h0;
    #1;
    ev_len = (q.size() > 0) ? need(q[0]) : 1;
    ev = !jv && q.size() > 0 && q.size() >= ev_len;
    chk(ins_valid == ev, "R6 valid", ins_valid, ev);
    if (ev) begin
      es = {q[0], (ev_len >= 2) ? q[1] : 8'h0, (ev_len == 3) ? q[2] : 8'h0};
      chk(ins_len == 2'(ev_len), "R2 len", ins_len, ev_len);
      chk(ins_syl == es, "R3 R4 syllables", ins_syl, es);
      chk(ins_kind == {es[23:22], es[15:14], es[7:6]}, "R11 kind", ins_kind, {es[23:22], es[15:14], es[7:6]});
      chk(ins_oct_a == {es[21:19], es[13:11], es[5:3]}, "R11 oct_a", ins_oct_a, {es[21:19], es[13:11], es[5:3]});
      chk(ins_oct_b == {es[18:16], es[10:8], es[2:0]}, "R11 oct_b", ins_oct_b, {es[18:16], es[10:8], es[2:0]});
    end
    if (prev_hold && !jv)
      chk(ins_valid && ins_syl == prev_syl, "R8 hold", ins_syl, prev_syl);
    if (mode == 0 && q.size() >= 3)
      chk(ins_valid, "R7 throughput", ins_valid, 1);
    er = !jv && !m_out && q.size() <= 6;
    chk(mem_req_valid == er, "R5 request", mem_req_valid, er);
    if (er) chk(mem_req_addr == 15'(m_addr), "R5 address", mem_req_addr, m_addr);
    prev_hold = ev && !rdy && !jv;
    prev_syl = ins_syl;
    fo = ev && rdy;
    fr = mem_req_valid && gnt;
    @(posedge clk);
    // memory model
    if (rv) mbusy = 0;
    else if (mbusy && mlat > 0) mlat--;
    if (fr) begin mbusy = 1; maddr = mem_req_addr; mlat = (lmax == 0) ? 0 : $urandom % (lmax + 1); end
    // reference model
    if (jv) begin
      q.delete();
      m_addr = jw; m_skip = js;
      m_drop = m_out && !rv;
      if (rv) m_out = 0;
    end else begin
      if (fo) for (int i = 0; i < ev_len; i++) void'(q.pop_front());
      if (rv) begin
        if (m_drop) m_drop = 0;
        else begin
          n = m_skip;
          for (int k = n; k < 6; k++) q.push_back(memword(maddr_prev(rv))[47-8*k -: 8]);
          m_skip = 0;
        end
        m_out = 0;
      end
      if (er && gnt) begin m_out = 1; m_addr = (m_addr + 1) & 32'h7fff; end
    end
  endtask

  // address of the word answered this cycle (captured before the memory update)
  int resp_addr_hold = 0;
  function automatic int maddr_prev(input bit dummy);
    return resp_addr_hold;
  endfunction

  task automatic run(input string ph, input int mode, input int n);
    phase = ph;
    for (int i = 0; i < n; i++) begin
      resp_addr_hold = maddr;
      cycle(mode);
    end
  endtask

  initial begin
    rst_n = 0; ins_ready = 0; mem_req_ready = 0; mem_resp_valid = 0;
    mem_resp_word = '0; jmp_valid = 0; jmp_word = '0; jmp_syl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ins_valid == 0, "R1 reset valid", ins_valid, 0);
    chk(mem_req_valid == 1, "R1 reset request", mem_req_valid, 1);
    chk(mem_req_addr == 0, "R1 reset address", mem_req_addr, 0);
    rst_n = 1;
    run("R7", 0, 300);
    run("R8", 1, 600);
    run("R9", 2, 1500);
    run("R10", 3, 800);
    run("R12", 4, 500);
    run("R13", 5, 500);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog [%s] act=%0d exp=%0d", phase, 20000, 4300);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule